// File: doc/BRIEF.md
# Device Configuration Sequencer

This block walks a programmable device through its configuration. It first clears the configuration memory. It then accepts configuration data, and finally runs a fixed startup window that turns on the user logic. It starts by itself once power-on reset is released. The host can delay the load phase with a hold-off input. An active-low program request restarts the whole flow from any point.

The sequencer tells the memory when to clear and waits for a clear-complete indication. It raises its init flag once clearing has finished and the hold-off is released, and it raises its done flag part way through startup. A load error drops the init flag and parks the sequencer until a new program request arrives. The formatting of the configuration data and the storage it lands in belong to other blocks.

Top module: `cfg_sequencer`

## Requirements
- R1: While `rst_n` is low, and for the two clock edges it takes to release the internal reset, the sequencer sits in the clear phase: `clear_cmd`=1, `init_o`=0, `done_o`=0, `logic_en`=0. With no further stimulus it stays in that phase after reset release.
- R2: `clear_cmd` is 1 exactly while the sequencer is in the clear phase. It drops on the edge after `clear_done` is sampled high, provided no program request is active.
- R3: After clearing, the sequencer enters a wait phase with `init_o`=0 and `clear_cmd`=0. It stays there while `hold_n` is low, and enters the load phase on the first edge that samples `hold_n` high.
- R4: `init_o` is 1 in the load, startup and running phases. It is 0 in the clear, wait and error phases.
- R5: In the load phase, `load_err` high moves the sequencer to the error phase, and it wins over a `load_done` in the same cycle. In the error phase `init_o`=0, `done_o`=0, `logic_en`=0 and `clear_cmd`=0. `load_done`, `hold_n` and `clear_done` have no effect there.
- R6: `load_done` high in the load phase starts a startup window of 8 cycles, numbered 0 to 7. The sequencer is in startup cycle 0 after the edge that sampled `load_done`. `done_o` rises in startup cycle 4, which is 5 clock edges after that sample, and stays high in the running phase that follows cycle 7.
- R7: `logic_en` rises in startup cycle 6 and stays high in the running phase.
- R8: `prog_n` is active low and passes through two synchronizing flops. A low sampled at edge k puts the sequencer in the clear phase from edge k+2. From then on `done_o`, `init_o` and `logic_en` are 0 and `clear_cmd` is 1 for as long as `prog_n` stays low, whatever `clear_done` does.
- R9: A program request restarts the flow from any phase, including running and error. A pulse of a single clock cycle is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low, released synchronously inside |
| prog_n | input | 1 | Program request, active low, asynchronous |
| hold_n | input | 1 | Hold-off; low delays the load phase |
| clear_done | input | 1 | Configuration memory reports clearing complete |
| load_done | input | 1 | Configuration data fully loaded |
| load_err | input | 1 | Error detected while loading |
| clear_cmd | output | 1 | Command to clear the configuration memory |
| init_o | output | 1 | Init flag: clearing finished and load allowed |
| done_o | output | 1 | Configuration complete flag |
| logic_en | output | 1 | Global enable for the user logic |

## Verification
The bench measures how many edges pass between a `load_done` sample and each rise of `done_o` and `logic_en`. A startup counter that is off by one would shift one of those counts away from 5 or 7. It also times a program request against the two-flop synchronizer. A design with one stage too few or too many would drop `done_o` a cycle early or late. A single-cycle request is sent into the error phase, where a sequencer that ignored short pulses or never left the error state would leave `clear_cmd` low. Load error and load done are raised together, and `clear_done` is kept high while `prog_n` is held low. This catches a design that gives the wrong input priority or leaves the clear phase while the request is still active.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    PH_CLEAR = 3'd0,
    PH_WAIT  = 3'd1,
    PH_LOAD  = 3'd2,
    PH_START = 3'd3,
    PH_RUN   = 3'd4,
    PH_ERR   = 3'd5
  } cfg_phase_e;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int STARTUP_LEN = 8,
  parameter int DONE_AT     = 4,
  parameter int EN_AT       = 6
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic prog_act,
  input  logic hold_n,
  input  logic clear_done,
  input  logic load_done,
  input  logic load_err,
  output logic clear_cmd,
  output logic init_o,
  output logic done_o,
  output logic logic_en
);
  localparam int CW = (STARTUP_LEN > 1) ? $clog2(STARTUP_LEN) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(STARTUP_LEN - 1);
  localparam logic [CW-1:0] DONE_CNT = CW'(DONE_AT);
  localparam logic [CW-1:0] EN_CNT   = CW'(EN_AT);

  cfg_phase_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // next-state
  always_comb begin
    state_d = state_q;
    if (prog_act) begin
      state_d = PH_CLEAR;
    end else begin
      unique case (state_q)
        PH_CLEAR: if (clear_done) state_d = PH_WAIT;
        PH_WAIT:  if (hold_n)     state_d = PH_LOAD;
        PH_LOAD: begin
          if (load_err)       state_d = PH_ERR;
          else if (load_done) state_d = PH_START;
        end
        PH_START: if (cnt_q == LAST_CNT) state_d = PH_RUN;
        PH_RUN:   state_d = PH_RUN;
        PH_ERR:   state_d = PH_ERR;
        default:  state_d = PH_CLEAR;
      endcase
    end
  end

  // startup counter: runs only in startup, returns to zero otherwise
  always_comb begin
    cnt_en = (state_q == PH_START) || (cnt_q != '0);
    cnt_d  = ((state_q == PH_START) && !prog_act && (cnt_q != LAST_CNT))
             ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_CLEAR;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Moore outputs
  always_comb begin
    clear_cmd = (state_q == PH_CLEAR);
    init_o    = (state_q == PH_LOAD) || (state_q == PH_START) || (state_q == PH_RUN);
    done_o    = (state_q == PH_RUN) || ((state_q == PH_START) && (cnt_q >= DONE_CNT));
    logic_en  = (state_q == PH_RUN) || ((state_q == PH_START) && (cnt_q >= EN_CNT));
  end

  // R8: an active request lands in the clear phase on the next edge
  a_r8_prog_forces_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    prog_act |=> (clear_cmd && !init_o && !done_o && !logic_en));

  // R5: the error phase is left only through a program request
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PH_ERR && !prog_act) |=> (state_q == PH_ERR && !init_o));

  // R3: hold-off keeps the wait phase
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PH_WAIT && !hold_n && !prog_act) |=> (state_q == PH_WAIT && !init_o));

  // R2: clear ends once the memory reports done
  a_r2_clear_exits: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear_cmd && clear_done && !prog_act) |=> !clear_cmd);

  // R6: the last startup cycle is followed by the running phase
  a_r6_startup_exit: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PH_START && cnt_q == LAST_CNT && !prog_act) |=> (state_q == PH_RUN && done_o));

  // R7: the logic enable never runs ahead of done
  a_r7_en_after_done: assert property (@(posedge clk) disable iff (!rst_ni)
    logic_en |-> done_o);

  // R4: done never shows without init
  a_r4_done_has_init: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> init_o);
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer #(
  parameter int STARTUP_LEN = 8,
  parameter int DONE_AT     = 4,
  parameter int EN_AT       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  input  logic hold_n,
  input  logic clear_done,
  input  logic load_done,
  input  logic load_err,
  output logic clear_cmd,
  output logic init_o,
  output logic done_o,
  output logic logic_en
);
  logic rst_sync_n;
  logic prog_sync_n;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfg_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .d_i    (prog_n),
    .q_o    (prog_sync_n)
  );

  cfg_seq_fsm #(
    .STARTUP_LEN (STARTUP_LEN),
    .DONE_AT     (DONE_AT),
    .EN_AT       (EN_AT)
  ) u_fsm (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .prog_act   (~prog_sync_n),
    .hold_n     (hold_n),
    .clear_done (clear_done),
    .load_done  (load_done),
    .load_err   (load_err),
    .clear_cmd  (clear_cmd),
    .init_o     (init_o),
    .done_o     (done_o),
    .logic_en   (logic_en)
  );
endmodule

// File: tb/cfg_sequencer_tb_top.sv
`timescale 1ns/1ps
module cfg_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n, prog_n, hold_n, clear_done, load_done, load_err;
  logic clear_cmd, init_o, done_o, logic_en;

  always #2.5 clk = ~clk;

  cfg_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .hold_n(hold_n),
    .clear_done(clear_done), .load_done(load_done), .load_err(load_err),
    .clear_cmd(clear_cmd), .init_o(init_o), .done_o(done_o), .logic_en(logic_en)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0b exp %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 clear,1 wait,2 load,3 startup,4 run,5 error
  int   ph;
  int   scyc;
  int   rdly;   // edges since rst_n release, saturating
  logic pq[$];  // prog_n samples, oldest first

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdly <= 0; ph <= 0; scyc <= 0;
      pq = {1'b1, 1'b1};
    end else if (rdly < 2) begin
      rdly <= rdly + 1;
      ph <= 0; scyc <= 0;
      pq = {1'b1, 1'b1};
    end else begin
      logic req;
      req = !pq[0];
      void'(pq.pop_front());
      pq.push_back(prog_n);
      if (req) begin
        ph <= 0; scyc <= 0;
      end else if (ph == 0) begin
        if (clear_done) ph <= 1;
      end else if (ph == 1) begin
        if (hold_n) ph <= 2;
      end else if (ph == 2) begin
        if (load_err) ph <= 5;
        else if (load_done) begin ph <= 3; scyc <= 0; end
      end else if (ph == 3) begin
        if (scyc == 7) begin ph <= 4; scyc <= 0; end
        else scyc <= scyc + 1;
      end
    end
  end

  always @(negedge clk) begin
    chk("R2", "clear_cmd", clear_cmd, ph == 0);
    chk("R4", "init_o",    init_o,    ph == 2 || ph == 3 || ph == 4);
    chk("R6", "done_o",    done_o,    ph == 4 || (ph == 3 && scyc >= 4));
    chk("R7", "logic_en",  logic_en,  ph == 4 || (ph == 3 && scyc >= 6));
  end

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // from clear phase with no request: reach load phase
  task automatic to_load();
    hold_n = 1'b1; clear_done = 1'b1;
    wn(1); clear_done = 1'b0;
    wn(1);
  endtask

  initial begin
    int dn_at, en_at;
    rst_n = 1'b0; prog_n = 1'b1; hold_n = 1'b1;
    clear_done = 1'b0; load_done = 1'b0; load_err = 1'b0;
    wn(3);
    chk("R1", "reset clear_cmd", clear_cmd, 1'b1);
    chk("R1", "reset init_o", init_o, 1'b0);
    chk("R1", "reset done_o", done_o, 1'b0);
    chk("R1", "reset logic_en", logic_en, 1'b0);
    rst_n = 1'b1;
    wn(6);
    chk("R1", "auto clear after reset", clear_cmd, 1'b1);

    // normal flow
    hold_n = 1'b1; clear_done = 1'b1;
    wn(1); clear_done = 1'b0;
    chk("R2", "clear left after clear_done", clear_cmd, 1'b0);
    wn(1);
    chk("R4", "init in load", init_o, 1'b1);

    // startup timing
    load_done = 1'b1; dn_at = 0; en_at = 0;
    for (int k = 1; k <= 12; k++) begin
      wn(1);
      if (k == 1) load_done = 1'b0;
      if (done_o && dn_at == 0) dn_at = k;
      if (logic_en && en_at == 0) en_at = k;
    end
    chk("R6", "done rises at startup cycle 4", dn_at == 5, 1'b1);
    chk("R7", "enable rises at startup cycle 6", en_at == 7, 1'b1);
    chk("R6", "done held in run", done_o, 1'b1);

    // program request from run: two-flop latency
    prog_n = 1'b0;
    wn(2);
    chk("R8", "done before sync delay", done_o, 1'b1);
    wn(1);
    chk("R8", "done dropped", done_o, 1'b0);
    chk("R9", "restart from run", clear_cmd, 1'b1);
    clear_done = 1'b1;
    wn(8);
    chk("R8", "held in clear while prog low", clear_cmd, 1'b1);
    chk("R8", "init low while prog low", init_o, 1'b0);
    prog_n = 1'b1; clear_done = 1'b0;
    wn(4);

    // hold-off
    hold_n = 1'b0; clear_done = 1'b1;
    wn(1); clear_done = 1'b0;
    wn(10);
    chk("R3", "wait keeps init low", init_o, 1'b0);
    chk("R3", "wait drops clear", clear_cmd, 1'b0);
    hold_n = 1'b1;
    wn(1);
    chk("R3", "load after hold release", init_o, 1'b1);

    // error wins over done
    load_err = 1'b1; load_done = 1'b1;
    wn(1); load_err = 1'b0; load_done = 1'b0;
    chk("R5", "error drops init", init_o, 1'b0);
    for (int k = 0; k < 6; k++) begin
      load_done = k[0]; clear_done = ~k[0]; hold_n = k[1];
      wn(1);
    end
    load_done = 1'b0; clear_done = 1'b0; hold_n = 1'b1;
    wn(1);
    chk("R5", "error ignores inputs init", init_o, 1'b0);
    chk("R5", "error ignores inputs done", done_o, 1'b0);
    chk("R5", "error not clearing", clear_cmd, 1'b0);

    // single-cycle request leaves error
    prog_n = 1'b0;
    wn(1); prog_n = 1'b1;
    wn(4);
    chk("R9", "pulse restarts from error", clear_cmd, 1'b1);

    // request during startup
    to_load();
    load_done = 1'b1;
    wn(1); load_done = 1'b0;
    wn(4);
    chk("R6", "done up in startup", done_o, 1'b1);
    prog_n = 1'b0;
    wn(3);
    chk("R8", "startup aborted done", done_o, 1'b0);
    chk("R8", "startup aborted enable", logic_en, 1'b0);
    prog_n = 1'b1;
    wn(4);
    to_load();
    load_done = 1'b1;
    wn(1); load_done = 1'b0;
    wn(12);
    chk("R7", "enable in run after restart", logic_en, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule